// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

This block keeps the descriptor table that a 10/100 Ethernet MAC shares with software and walks it in two rings. The leading entries of the table form the transmit ring, and the rest form the receive ring. A programmable transmit-count register sets where the table splits. Software fills descriptors through a simple register bus. For each ready transmit descriptor, the sequencer presents its buffer address, length and pad/CRC flags to the MAC over a request/done handshake. On done, it writes the completion status back. For each incoming frame, it claims the next empty receive descriptor and later writes back the frame length and error flags.

A write-one-to-clear interrupt source register collects good and error completions for each direction, plus dropped frames. A single `irq` output is the OR of its bits.

Each ring runs a small state machine. Transmit has TX_OFF, TX_SCAN and TX_XFER. TX_OFF goes to TX_SCAN when the transmit enable is set. TX_SCAN goes to TX_XFER when the descriptor at the pointer is ready. TX_XFER goes back to TX_SCAN on done, and the pointer advances at that point. Receive has RX_OFF, RX_IDLE and RX_FILL. RX_OFF goes to RX_IDLE when enabled. RX_IDLE goes to RX_FILL on a frame start that finds an empty descriptor; a start that finds no empty descriptor leaves the machine in RX_IDLE and records a drop. RX_FILL goes back to RX_IDLE on frame done. In either machine, clearing the enable sends any state to OFF.

Top module: `bdr_seq`

## Requirements
- R1: The descriptor table is mapped at byte offset 0x400, 8 bytes per descriptor. Each descriptor has a status word at +0 and a buffer address word at +4, and software can write and read back both words.
- R2: The transmit-count register at offset 0x004 resets to NUM_DESC/2. A write above min(128, NUM_DESC) is clamped to that limit. Receive descriptors start at the index equal to this count.
- R3: The transmit engine examines the descriptor at its pointer. If status bit 15 (ready) is set, `tx_req` rises on the next cycle and stays high until `tx_done`. While `tx_req` is high, `tx_buf_addr` is the address word, `tx_len` is status bits 31:16, `tx_pad` is bit 12 and `tx_crc` is bit 11. A descriptor that is not ready stalls the engine on that descriptor; the engine does not skip past it.
- R4: On `tx_done`, the status word's bits 8:0 take `tx_done_stat` and bit 15 is cleared. All other status bits are kept, and the pointer advances.
- R5: After a completion, the next index is the ring base in either of two cases: status bit 13 (wrap) is set, or the index is the ring's last entry (count−1 for transmit, NUM_DESC−1 for receive). Otherwise the next index is one higher. The transmit ring base is 0; the receive ring base is the transmit count.
- R6: A `rx_start` pulse in RX_IDLE claims the descriptor at the receive pointer if its status bit 15 (empty) is set. In that case `rx_claim` rises on the next cycle, with `rx_buf_addr` giving the address word. If the descriptor is not empty, nothing is claimed and interrupt bit 4 is set.
- R7: On `rx_done`, the status word becomes the following, and the pointer advances:
  - bits 31:16 take `rx_len`;
  - bit 15 is cleared;
  - bits 14:9 are kept;
  - bits 8:0 take `rx_done_stat`.
- R8: Interrupt source bits are set only when the completed descriptor has status bit 14 set:
  - bit 0: good transmit;
  - bit 1: transmit error, meaning any of `tx_done_stat` bits 0, 2, 3 or 8;
  - bit 2: good receive, where bit 8 (control frame) alone is not an error;
  - bit 3: receive error, meaning any of `rx_done_stat` bits 7:0.
  
  `irq` is the OR of all five source bits.
- R9: The interrupt source register is at offset 0x000. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R10: Clearing `tx_en` or `rx_en` drops `tx_req` or `rx_claim` on the next cycle and returns that ring's pointer to its ring base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_en | input | 1 | Transmit ring enable |
| rx_en | input | 1 | Receive ring enable |
| tx_req | output | 1 | Transmit descriptor presented to the MAC |
| tx_buf_addr | output | 32 | Transmit buffer address |
| tx_len | output | 16 | Transmit frame length |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append CRC |
| tx_done | input | 1 | Transmit completion pulse |
| tx_done_stat | input | 9 | Transmit completion status |
| rx_start | input | 1 | Incoming frame start pulse |
| rx_claim | output | 1 | Receive descriptor claimed for current frame |
| rx_buf_addr | output | 32 | Receive buffer address |
| rx_done | input | 1 | Receive completion pulse |
| rx_len | input | 16 | Received frame length |
| rx_done_stat | input | 9 | Receive completion status |
| irq | output | 1 | OR of interrupt source bits |

## Verification
The embedded assertions check every cycle that:
- a transmit request or receive claim is held until its done pulse;
- clearing an enable drops the handshake and rewinds the transmit pointer;
- a write-one-to-clear removes a pending transmit-good bit unless a new completion sets it again.

Some behaviours depend on table contents, so only the bench's scenarios can show them:
- descriptor writeback contents;
- wrap back to each ring's base;
- stalling on a non-ready descriptor;
- dropping a frame when no receive descriptor is empty;
- the count clamp.

The bench compares `tx_req`, the presented descriptor fields, `rx_claim`, `rx_buf_addr` and `irq` against a behavioural model on every clock.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
    // status word bit positions shared by both rings
    localparam int ST_OWN  = 15;
    localparam int ST_IRQ  = 14;
    localparam int ST_WRAP = 13;
    localparam int ST_PAD  = 12;
    localparam int ST_CRC  = 11;
    localparam int DONE_W  = 9;

    // completion flags that count as errors
    localparam logic [DONE_W-1:0] TX_ERR_MASK = 9'h10D;
    localparam logic [DONE_W-1:0] RX_ERR_MASK = 9'h0FF;

    typedef enum logic [1:0] {TX_OFF, TX_SCAN, TX_XFER} tx_state_e;
    typedef enum logic [1:0] {RX_OFF, RX_IDLE, RX_FILL} rx_state_e;
endpackage

// File: rtl/bdr_table.sv
module bdr_table #(
    parameter int NUM_DESC = 32,
    parameter int IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic             sw_word,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      sw_rdata,
    input  logic             tx_we,
    input  logic [IDX_W-1:0] tx_idx,
    input  logic [31:0]      tx_wstat,
    output logic [31:0]      tx_stat,
    output logic [31:0]      tx_addr,
    input  logic             rx_we,
    input  logic [IDX_W-1:0] rx_idx,
    input  logic [31:0]      rx_wstat,
    output logic [31:0]      rx_stat,
    output logic [31:0]      rx_addr
);
    logic [31:0] stat_q [NUM_DESC];
    logic [31:0] addr_q [NUM_DESC];

    // engine writebacks come last so they win over a same-cycle software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DESC; i++) begin
                stat_q[i] <= '0;
                addr_q[i] <= '0;
            end
        end else begin
            if (sw_we && !sw_word) stat_q[sw_idx] <= sw_wdata;
            if (sw_we &&  sw_word) addr_q[sw_idx] <= sw_wdata;
            if (tx_we) stat_q[tx_idx] <= tx_wstat;
            if (rx_we) stat_q[rx_idx] <= rx_wstat;
        end
    end

    always_comb begin
        sw_rdata = sw_word ? addr_q[sw_idx] : stat_q[sw_idx];
        tx_stat  = stat_q[tx_idx];
        tx_addr  = addr_q[tx_idx];
        rx_stat  = stat_q[rx_idx];
        rx_addr  = addr_q[rx_idx];
    end
endmodule

// File: rtl/bdr_tx_ring.sv
module bdr_tx_ring
    import bdr_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [IDX_W:0]    txcnt,
    input  logic [31:0]       desc_stat,
    input  logic              done,
    input  logic [DONE_W-1:0] done_stat,
    output logic [IDX_W-1:0]  ptr,
    output logic              req,
    output logic              wb_we,
    output logic [31:0]       wb_stat,
    output logic              int_good,
    output logic              int_err
);
    tx_state_e        state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [IDX_W:0]   last_idx;
    logic             at_end;
    logic             is_err;

    assign last_idx = txcnt - 1'b1;
    assign at_end   = desc_stat[ST_WRAP] || ({1'b0, ptr_q} == last_idx);

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (!en) begin
            state_d = TX_OFF;
            ptr_d   = '0;
        end else begin
            unique case (state_q)
                TX_OFF:  state_d = TX_SCAN;
                TX_SCAN: if (txcnt != '0 && desc_stat[ST_OWN]) state_d = TX_XFER;
                TX_XFER: if (done) begin
                    state_d = TX_SCAN;
                    ptr_d   = at_end ? '0 : ptr_q + 1'b1;
                end
                default: state_d = TX_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_OFF;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        ptr      = ptr_q;
        req      = (state_q == TX_XFER);
        wb_we    = req && done;
        wb_stat  = {desc_stat[31:16], 1'b0, desc_stat[14:9], done_stat};
        is_err   = |(done_stat & TX_ERR_MASK);
        int_good = wb_we && desc_stat[ST_IRQ] && !is_err;
        int_err  = wb_we && desc_stat[ST_IRQ] &&  is_err;
    end

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !done && en) |=> req);
    // R10
    tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!req && ptr_q == '0));
endmodule

// File: rtl/bdr_rx_ring.sv
module bdr_rx_ring
    import bdr_pkg::*;
#(
    parameter int NUM_DESC = 32,
    parameter int IDX_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [IDX_W:0]    base,
    input  logic [31:0]       desc_stat,
    input  logic              start,
    input  logic              done,
    input  logic [15:0]       done_len,
    input  logic [DONE_W-1:0] done_stat,
    output logic [IDX_W-1:0]  ptr,
    output logic              claim,
    output logic              wb_we,
    output logic [31:0]       wb_stat,
    output logic              int_good,
    output logic              int_err,
    output logic              int_drop
);
    localparam logic [IDX_W:0]   DEPTH_C = (IDX_W+1)'(NUM_DESC);
    localparam logic [IDX_W-1:0] LAST_C  = IDX_W'(NUM_DESC - 1);

    rx_state_e        state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic             ring_ok, at_end, is_err;

    assign ring_ok = (base < DEPTH_C);
    assign at_end  = desc_stat[ST_WRAP] || (ptr_q == LAST_C);

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (!en) begin
            state_d = RX_OFF;
            ptr_d   = base[IDX_W-1:0];
        end else begin
            unique case (state_q)
                RX_OFF: begin
                    state_d = RX_IDLE;
                    ptr_d   = base[IDX_W-1:0];
                end
                RX_IDLE: if (start && ring_ok && desc_stat[ST_OWN]) state_d = RX_FILL;
                RX_FILL: if (done) begin
                    state_d = RX_IDLE;
                    ptr_d   = at_end ? base[IDX_W-1:0] : ptr_q + 1'b1;
                end
                default: state_d = RX_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_OFF;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        ptr      = ptr_q;
        claim    = (state_q == RX_FILL);
        wb_we    = claim && done;
        wb_stat  = {done_len, 1'b0, desc_stat[14:9], done_stat};
        is_err   = |(done_stat & RX_ERR_MASK);
        int_good = wb_we && desc_stat[ST_IRQ] && !is_err;
        int_err  = wb_we && desc_stat[ST_IRQ] &&  is_err;
        int_drop = en && (state_q == RX_IDLE) && start && !(ring_ok && desc_stat[ST_OWN]);
    end

    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !done && en) |=> claim);
    // R10
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !claim);
endmodule

// File: rtl/bdr_seq.sv
module bdr_seq
    import bdr_pkg::*;
#(
    parameter int NUM_DESC = 32,
    parameter int ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tx_en,
    input  logic              rx_en,
    output logic              tx_req,
    output logic [31:0]       tx_buf_addr,
    output logic [15:0]       tx_len,
    output logic              tx_pad,
    output logic              tx_crc,
    input  logic              tx_done,
    input  logic [8:0]        tx_done_stat,
    input  logic              rx_start,
    output logic              rx_claim,
    output logic [31:0]       rx_buf_addr,
    input  logic              rx_done,
    input  logic [15:0]       rx_len,
    input  logic [8:0]        rx_done_stat,
    output logic              irq
);
    // table index is sliced straight from the address: NUM_DESC must be <= 128
    localparam int IDX_W  = $clog2(NUM_DESC);
    localparam int CNT_W  = IDX_W + 1;
    localparam int MAX_TX = (NUM_DESC < 128) ? NUM_DESC : 128;
    localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_TLO  = ADDR_W'(1024);
    localparam logic [ADDR_W-1:0] A_THI  = ADDR_W'(1024 + NUM_DESC * 8);
    localparam logic [CNT_W-1:0]  CNT_RST = CNT_W'(NUM_DESC / 2);

    logic             sel_int, sel_cnt, sel_tab;
    logic [CNT_W-1:0] txcnt_q;
    logic [4:0]       int_q, int_set;
    logic [31:0]      tab_rdata;
    logic [IDX_W-1:0] tx_ptr, rx_ptr;
    logic [31:0]      tx_dstat, tx_daddr, rx_dstat, rx_daddr;
    logic             tx_wb, rx_wb;
    logic [31:0]      tx_wstat, rx_wstat;
    logic             tx_good, tx_bad, rx_good, rx_bad, rx_drop;

    assign sel_int = (reg_addr == A_INT);
    assign sel_cnt = (reg_addr == A_CNT);
    assign sel_tab = (reg_addr >= A_TLO) && (reg_addr < A_THI);

    bdr_table #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .sw_we(reg_we && sel_tab), .sw_idx(reg_addr[IDX_W+2:3]),
        .sw_word(reg_addr[2]), .sw_wdata(reg_wdata), .sw_rdata(tab_rdata),
        .tx_we(tx_wb), .tx_idx(tx_ptr), .tx_wstat(tx_wstat),
        .tx_stat(tx_dstat), .tx_addr(tx_daddr),
        .rx_we(rx_wb), .rx_idx(rx_ptr), .rx_wstat(rx_wstat),
        .rx_stat(rx_dstat), .rx_addr(rx_daddr)
    );

    bdr_tx_ring #(.IDX_W(IDX_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .txcnt(txcnt_q),
        .desc_stat(tx_dstat), .done(tx_done), .done_stat(tx_done_stat),
        .ptr(tx_ptr), .req(tx_req), .wb_we(tx_wb), .wb_stat(tx_wstat),
        .int_good(tx_good), .int_err(tx_bad)
    );

    bdr_rx_ring #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .base(txcnt_q),
        .desc_stat(rx_dstat), .start(rx_start), .done(rx_done),
        .done_len(rx_len), .done_stat(rx_done_stat),
        .ptr(rx_ptr), .claim(rx_claim), .wb_we(rx_wb), .wb_stat(rx_wstat),
        .int_good(rx_good), .int_err(rx_bad), .int_drop(rx_drop)
    );

    assign int_set = {rx_drop, rx_bad, rx_good, tx_bad, tx_good};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txcnt_q <= CNT_RST;
            int_q   <= '0;
        end else begin
            if (reg_we && sel_cnt) begin
                if (reg_wdata > 32'(MAX_TX)) txcnt_q <= CNT_W'(MAX_TX);
                else                         txcnt_q <= reg_wdata[CNT_W-1:0];
            end
            int_q <= (int_q & ~((reg_we && sel_int) ? reg_wdata[4:0] : 5'd0)) | int_set;
        end
    end

    always_comb begin
        if (sel_int)      reg_rdata = {27'd0, int_q};
        else if (sel_cnt) reg_rdata = 32'(txcnt_q);
        else if (sel_tab) reg_rdata = tab_rdata;
        else              reg_rdata = '0;
        tx_buf_addr = tx_daddr;
        tx_len      = tx_dstat[31:16];
        tx_pad      = tx_dstat[ST_PAD];
        tx_crc      = tx_dstat[ST_CRC];
        rx_buf_addr = rx_daddr;
        irq         = |int_q;
    end

    // R9
    int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && sel_int && reg_wdata[0] && !tx_good) |=> !int_q[0]);
endmodule

// File: tb/sim_bdr_seq.sv
module sim_bdr_seq;
    localparam int CLK_P = 10;
    localparam int N     = 32;

    logic        clk = 0, rst_n = 0;
    logic        reg_we = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        tx_en = 0, rx_en = 0;
    logic        tx_req, tx_pad, tx_crc, rx_claim, irq;
    logic [31:0] tx_buf_addr, rx_buf_addr;
    logic [15:0] tx_len;
    logic        tx_done = 0, rx_start = 0, rx_done = 0;
    logic [8:0]  tx_done_stat = 0, rx_done_stat = 0;
    logic [15:0] rx_len = 0;

    int total = 0, bad = 0;
    bit finished = 0;

    bdr_seq #(.NUM_DESC(N), .ADDR_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_en(tx_en), .rx_en(rx_en),
        .tx_req(tx_req), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
        .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .tx_done_stat(tx_done_stat),
        .rx_start(rx_start), .rx_claim(rx_claim), .rx_buf_addr(rx_buf_addr),
        .rx_done(rx_done), .rx_len(rx_len), .rx_done_stat(rx_done_stat), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_st [N];
    bit [31:0] m_ad [N];
    int        m_cnt, m_tp, m_rp, m_ts, m_rs;   // states: 0 off, 1 scan/idle, 2 busy
    bit [4:0]  m_int;

    always @(posedge clk) begin
        bit [31:0] ts, rs;
        int ntp, nrp, nts, nrs, ncnt, ti, ri;
        bit [4:0] set, clr;
        bit twb, rwb;
        bit [31:0] tws, rws;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_st[i] = 0; m_ad[i] = 0; end
            m_cnt = N/2; m_tp = 0; m_rp = 0; m_ts = 0; m_rs = 0; m_int = 0;
        end else begin
            ts = m_st[m_tp]; rs = m_st[m_rp];
            ntp = m_tp; nrp = m_rp; nts = m_ts; nrs = m_rs;
            set = 0; clr = 0; twb = 0; rwb = 0; tws = 0; rws = 0;
            ti = m_tp; ri = m_rp;
            if (!tx_en) begin nts = 0; ntp = 0; end
            else if (m_ts == 0) nts = 1;
            else if (m_ts == 1) begin if (m_cnt != 0 && ts[15]) nts = 2; end
            else if (tx_done) begin
                nts = 1;
                ntp = (ts[13] || m_tp == m_cnt - 1) ? 0 : m_tp + 1;
                twb = 1;
                tws = {ts[31:16], 1'b0, ts[14:9], tx_done_stat};
                if (ts[14]) begin
                    if ((tx_done_stat & 9'h10D) != 0) set[1] = 1; else set[0] = 1;
                end
            end
            if (!rx_en) begin nrs = 0; nrp = m_cnt % N; end
            else if (m_rs == 0) begin nrs = 1; nrp = m_cnt % N; end
            else if (m_rs == 1) begin
                if (rx_start) begin
                    if (m_cnt < N && rs[15]) nrs = 2; else set[4] = 1;
                end
            end else if (rx_done) begin
                nrs = 1;
                nrp = (rs[13] || m_rp == N - 1) ? m_cnt % N : m_rp + 1;
                rwb = 1;
                rws = {rx_len, 1'b0, rs[14:9], rx_done_stat};
                if (rs[14]) begin
                    if (rx_done_stat[7:0] != 0) set[3] = 1; else set[2] = 1;
                end
            end
            ncnt = m_cnt;
            if (reg_we) begin
                if (reg_addr == 0) clr = reg_wdata[4:0];
                else if (reg_addr == 4) ncnt = (reg_wdata > 32) ? 32 : int'(reg_wdata);
                else if (reg_addr >= 12'h400 && reg_addr < 12'h400 + N*8) begin
                    if (reg_addr[2]) m_ad[reg_addr[7:3]] = reg_wdata;
                    else             m_st[reg_addr[7:3]] = reg_wdata;
                end
            end
            if (twb) m_st[ti] = tws;
            if (rwb) m_st[ri] = rws;
            m_int = (m_int & ~clr) | set;
            m_cnt = ncnt; m_tp = ntp; m_rp = nrp; m_ts = nts; m_rs = nrs;
        end
    end

    // per-cycle comparison of registered outputs, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(tx_req == (m_ts == 2), "R3 tx_req per-cycle", 32'(tx_req), 32'(m_ts == 2));
            if (m_ts == 2) begin
                chk(tx_buf_addr == m_ad[m_tp], "R3 tx_buf_addr", tx_buf_addr, m_ad[m_tp]);
                chk({tx_len, tx_pad, tx_crc} == {m_st[m_tp][31:16], m_st[m_tp][12], m_st[m_tp][11]},
                    "R3 tx_len/pad/crc", {14'd0, tx_len, tx_pad, tx_crc},
                    {14'd0, m_st[m_tp][31:16], m_st[m_tp][12], m_st[m_tp][11]});
            end
            chk(rx_claim == (m_rs == 2), "R6 rx_claim per-cycle", 32'(rx_claim), 32'(m_rs == 2));
            if (m_rs == 2)
                chk(rx_buf_addr == m_ad[m_rp], "R6 rx_buf_addr", rx_buf_addr, m_ad[m_rp]);
            chk(irq == (m_int != 0), "R8 irq per-cycle", 32'(irq), 32'(m_int != 0));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_addr = a; #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic tx_finish(input logic [8:0] st, input string tag);
        for (int i = 0; i < 50 && !tx_req; i++) @(negedge clk);
        chk(tx_req === 1'b1, tag, 32'(tx_req), 32'd1);
        tx_done = 1; tx_done_stat = st;
        @(negedge clk); tx_done = 0;
    endtask

    task automatic rx_frame(input logic [15:0] len, input logic [8:0] st,
                            input bit exp_claim, input logic [31:0] exp_addr, input string tag);
        bit got;
        logic [31:0] a;
        @(negedge clk); rx_start = 1;
        @(negedge clk); rx_start = 0;
        got = rx_claim; a = rx_buf_addr;
        chk(got == exp_claim, tag, 32'(got), 32'(exp_claim));
        if (exp_claim) chk(a == exp_addr, tag, a, exp_addr);
        if (got) begin
            rx_done = 1; rx_len = len; rx_done_stat = st;
            @(negedge clk); rx_done = 0;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state
        rd(12'h000, 0, "R9 reset int source");
        rd(12'h004, N/2, "R2 reset tx count");
        chk(tx_req == 0 && rx_claim == 0, "R3 idle after reset", {tx_req, rx_claim}, 0);
        // count clamp
        wr(12'h004, 200); rd(12'h004, 32, "R2 clamp");
        wr(12'h004, 4);   rd(12'h004, 4,  "R2 write");
        // transmit descriptors 0..3
        wr(12'h400, 32'h003C_D000); wr(12'h404, 32'h1000);   // len 60, ready irq pad
        wr(12'h408, 32'h0064_C800); wr(12'h40C, 32'h2000);   // len 100, ready irq crc
        wr(12'h410, 32'h0046_0000); wr(12'h414, 32'h3000);   // not ready yet
        wr(12'h418, 32'h0050_E000); wr(12'h41C, 32'h4000);   // ready irq wrap
        rd(12'h40C, 32'h2000, "R1 address word readback");
        rd(12'h408, 32'h0064_C800, "R1 status word readback");
        tx_en = 1;
        tx_finish(9'h000, "R3 first request");
        rd(12'h400, 32'h003C_5000, "R4 tx writeback good");
        rd(12'h000, 1, "R8 tx good bit");
        tx_finish(9'h004, "R3 second request");
        rd(12'h408, 32'h0064_4804, "R4 tx writeback late collision");
        rd(12'h000, 3, "R8 tx error bit");
        wr(12'h000, 1); rd(12'h000, 2, "R9 write-one-to-clear");
        // stall on not-ready descriptor 2
        repeat (10) @(negedge clk);
        chk(tx_req == 0, "R3 stall on not-ready", 32'(tx_req), 0);
        wr(12'h410, 32'h0046_8000);   // ready, no irq
        tx_finish(9'h000, "R3 resume after stall");
        rd(12'h410, 32'h0046_0000, "R4 writeback without irq");
        rd(12'h000, 2, "R8 no bit when irq disabled");
        tx_finish(9'h010, "R3 wrap descriptor");
        rd(12'h418, 32'h0050_6010, "R4 retry count kept as status");
        rd(12'h000, 3, "R8 retry count is not an error");
        // wrap back to index 0
        wr(12'h400, 32'h003C_8000);
        for (int i = 0; i < 20 && !tx_req; i++) @(negedge clk);
        chk(tx_buf_addr == 32'h1000, "R5 tx wrap to base", tx_buf_addr, 32'h1000);
        tx_finish(9'h000, "R5 wrap request");
        // disable mid-request rewinds to 0
        wr(12'h408, 32'h0064_8000);
        for (int i = 0; i < 20 && !tx_req; i++) @(negedge clk);
        chk(tx_buf_addr == 32'h2000, "R3 request on index 1", tx_buf_addr, 32'h2000);
        tx_en = 0;
        @(negedge clk); @(negedge clk);
        chk(tx_req == 0, "R10 tx_req drops", 32'(tx_req), 0);
        wr(12'h400, 32'h003C_8000);
        tx_en = 1;
        for (int i = 0; i < 20 && !tx_req; i++) @(negedge clk);
        chk(tx_buf_addr == 32'h1000, "R10 tx pointer back to base", tx_buf_addr, 32'h1000);
        tx_finish(9'h000, "R10 restart");
        tx_en = 0;
        wr(12'h000, 31); rd(12'h000, 0, "R9 clear all");
        // receive ring begins at index 4
        wr(12'h420, 32'h0000_C000); wr(12'h424, 32'h5000);
        wr(12'h428, 32'h0000_E000); wr(12'h42C, 32'h6000);
        rx_en = 1; repeat (2) @(negedge clk);
        rx_frame(100, 9'h000, 1, 32'h5000, "R6 claim first rx");
        rd(12'h420, 32'h0064_4000, "R7 rx writeback good");
        rd(12'h000, 4, "R8 rx good bit");
        rx_frame(64, 9'h002, 1, 32'h6000, "R6 claim second rx");
        rd(12'h428, 32'h0040_6002, "R7 rx writeback crc error");
        rd(12'h000, 12, "R8 rx error bit");
        rx_frame(10, 9'h000, 0, 0, "R5 rx wrap finds full descriptor");
        rd(12'h000, 28, "R6 drop bit");
        wr(12'h000, 31);
        wr(12'h420, 32'h0000_C000);
        rx_frame(60, 9'h100, 1, 32'h5000, "R5 rx wrapped to base");
        rd(12'h420, 32'h003C_4100, "R7 control frame status");
        rd(12'h000, 4, "R8 control frame is good");
        // disable rewinds rx pointer to ring base
        wr(12'h428, 32'h0000_C000);
        rx_en = 0; repeat (2) @(negedge clk);
        wr(12'h420, 32'h0000_C000);
        rx_en = 1; repeat (2) @(negedge clk);
        rx_frame(61, 9'h000, 1, 32'h5000, "R10 rx pointer back to base");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule